// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

This block sits between a set of external interrupt request lines and the trap logic of a processor core. Every clock cycle it looks at the fifteen request levels, picks the highest one that is asserted, and turns it into an external-interrupt trap type. It keeps the result as the pending trap index, and it holds a request line high toward the core for as long as that index is nonzero. A one-cycle notify strobe fires only when the held index takes on a new nonzero value, so the core is not signalled again while the same request stays pending.

Other units can also place a synchronous trap index in the same holding register through a load port. Such an index stays in place while levels come and go: the level logic only writes the register when it is empty or already holds an external-interrupt type. When the core accepts a trap, it pulses the acceptance input and the register empties. No masking against a processor interrupt level is done here.

Top module: `irl_resolver`

## Requirements
- R1: While reset is high, and on the cycle after it is released, `pend_idx` is 0x00 and both `core_req` and `core_kick` are low.
- R2: When the held index is 0x00 or an external-interrupt type, and neither `trap_taken` nor `sync_load` is high, the next `pend_idx` is 0x10 OR-ed with the highest numbered asserted level among bits 15..1 of `irq_lines`. Levels 1..15 map to 0x11..0x1F.
- R3: Bit 0 of `irq_lines` has no effect. A vector with only bit 0 set leaves an empty index at 0x00.
- R4: A held index that is nonzero and not an external-interrupt type is not changed by any pattern on `irq_lines`. An external-interrupt type is one whose bits 7..4 equal 4'h1.
- R5: When bits 15..1 of `irq_lines` are all low and the held index is an external-interrupt type, the next `pend_idx` is 0x00 and `core_req` drops.
- R6: A held index that is nonzero and not an external-interrupt type stays unchanged while all levels are low.
- R7: `core_kick` is high for exactly the cycle after `pend_idx` changes to a different nonzero value. It stays low while the index is unchanged or becomes 0x00.
- R8: `sync_load` high with `trap_taken` low writes `sync_idx` into `pend_idx` on the next cycle. This takes precedence over the levels and over any held value.
- R9: `trap_taken` high makes the next `pend_idx` 0x00 and lowers `core_req`. It takes precedence over `sync_load` and over the levels.
- R10: `core_req` is high exactly when `pend_idx` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Request levels; bit n requests level n, bit 0 unused |
| sync_load | input | 1 | Write `sync_idx` into the pending index |
| sync_idx | input | 8 | Synchronous trap index from another unit |
| trap_taken | input | 1 | Core accepted the pending trap; empty the index |
| pend_idx | output | 8 | Pending trap index, 0x00 when empty |
| core_req | output | 1 | Trap request level toward the core |
| core_kick | output | 1 | One-cycle strobe when the index takes a new nonzero value |

## Verification
The assertions assume that every input is a clean synchronous level that is stable around the rising edge. They also assume that `sync_load` and `trap_taken` may coincide, with the acceptance input winning. They make no assumption about how long a level stays asserted, so single-cycle glitches on the request lines are legal stimulus. The bench changes inputs only on falling edges. It covers overlapping load and acceptance and level vectors that change on consecutive cycles, and it loads both interrupt-type and non-interrupt indices so that the held-index rules are reached from each kind of content.

// File: rtl/irl_pkg.sv
package irl_pkg;

    localparam int LINE_W    = 16;
    localparam int IDX_W     = 8;
    localparam int LVL_W     = $clog2(LINE_W);
    localparam int EXT_TAG_W = IDX_W - LVL_W;

    typedef logic [IDX_W-1:0] trap_idx_t;
    typedef logic [LVL_W-1:0] level_t;

    localparam trap_idx_t EXT_BASE = trap_idx_t'(8'h10);

    typedef struct packed {
        logic   hit;
        level_t lvl;
    } prio_t;

    typedef enum logic [2:0] {
        UPD_HOLD,
        UPD_ACCEPT,
        UPD_LOAD,
        UPD_IRQ,
        UPD_DROP
    } upd_e;

    typedef struct packed {
        upd_e      kind;
        trap_idx_t nxt;
    } upd_t;

    function automatic logic is_ext(input trap_idx_t idx);
        return idx[IDX_W-1:LVL_W] == EXT_BASE[IDX_W-1:LVL_W];
    endfunction

    function automatic trap_idx_t mk_ext(input level_t lvl);
        return EXT_BASE | {{EXT_TAG_W{1'b0}}, lvl};
    endfunction

endpackage

// File: rtl/irl_prio_enc.sv
module irl_prio_enc
    import irl_pkg::*;
#(
    parameter int W = LINE_W
) (
    input  logic [W-1:0] lines,
    output prio_t        prio
);
    // each stage forwards the winner of the lines above it; bit 0 never wins
    prio_t stage [W+1];

    assign stage[W] = '0;

    generate
        for (genvar g = W - 1; g >= 0; g--) begin : g_stage
            if (g == 0) begin : g_skip
                assign stage[g] = stage[g+1];
            end else begin : g_bit
                assign stage[g] = stage[g+1].hit ? stage[g+1]
                                : (lines[g] ? prio_t'{hit: 1'b1, lvl: level_t'(g)}
                                            : prio_t'('0));
            end
        end
    endgenerate

    assign prio = stage[0];
endmodule

// File: rtl/irl_update_sel.sv
module irl_update_sel
    import irl_pkg::*;
(
    input  trap_idx_t cur,
    input  prio_t     prio,
    input  logic      sync_load,
    input  trap_idx_t sync_idx,
    input  logic      trap_taken,
    output upd_t      upd
);
    logic cur_open;

    // levels may only write an empty index or one they wrote themselves
    assign cur_open = (cur == '0) || is_ext(cur);

    always_comb begin
        upd.kind = UPD_HOLD;
        upd.nxt  = cur;
        if (trap_taken) begin
            upd.kind = UPD_ACCEPT;
            upd.nxt  = '0;
        end else if (sync_load) begin
            upd.kind = UPD_LOAD;
            upd.nxt  = sync_idx;
        end else if (prio.hit && cur_open) begin
            upd.kind = UPD_IRQ;
            upd.nxt  = mk_ext(prio.lvl);
        end else if (!prio.hit && is_ext(cur)) begin
            upd.kind = UPD_DROP;
            upd.nxt  = '0;
        end
    end
endmodule

// File: rtl/irl_hold_reg.sv
module irl_hold_reg
    import irl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  upd_t      upd,
    output trap_idx_t idx,
    output logic      req,
    output logic      kick
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            req  <= 1'b0;
            kick <= 1'b0;
        end else begin
            idx  <= upd.nxt;
            kick <= (upd.nxt != idx) && (upd.nxt != '0);
            case (upd.kind)
                UPD_ACCEPT, UPD_DROP: req <= 1'b0;
                UPD_LOAD, UPD_IRQ:    req <= (upd.nxt != '0);
                default:              req <= req;
            endcase
        end
    end
endmodule

// File: rtl/irl_resolver.sv
module irl_resolver
    import irl_pkg::*;
#(
    parameter int LINES = LINE_W,
    parameter int IW    = IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] irq_lines,
    input  logic             sync_load,
    input  logic [IW-1:0]    sync_idx,
    input  logic             trap_taken,
    output logic [IW-1:0]    pend_idx,
    output logic             core_req,
    output logic             core_kick
);
    prio_t     prio;
    upd_t      upd;
    trap_idx_t held;

    irl_prio_enc #(.W(LINES)) u_prio (
        .lines (irq_lines),
        .prio  (prio)
    );

    irl_update_sel u_sel (
        .cur        (held),
        .prio       (prio),
        .sync_load  (sync_load),
        .sync_idx   (trap_idx_t'(sync_idx)),
        .trap_taken (trap_taken),
        .upd        (upd)
    );

    irl_hold_reg u_hold (
        .clk  (clk),
        .rst  (rst),
        .upd  (upd),
        .idx  (held),
        .req  (core_req),
        .kick (core_kick)
    );

    assign pend_idx = IW'(held);
endmodule

// File: rtl/irl_resolver_chk.sv
module irl_resolver_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] irq_lines,
    input logic        sync_load,
    input logic [7:0]  sync_idx,
    input logic        trap_taken,
    input logic [7:0]  pend_idx,
    input logic        core_req,
    input logic        core_kick
);
    logic ext_held;
    logic any_lvl;
    assign ext_held = pend_idx[7:4] == 4'h1;
    assign any_lvl  = |irq_lines[15:1];

    p_req_match_r10: assert property (@(posedge clk) disable iff (rst)
        core_req == (pend_idx != 8'h00));

    p_accept_clears_r9: assert property (@(posedge clk) disable iff (rst)
        trap_taken |=> (pend_idx == 8'h00) && !core_req);

    p_load_writes_r8: assert property (@(posedge clk) disable iff (rst)
        (sync_load && !trap_taken) |=> pend_idx == $past(sync_idx));

    p_sync_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (!trap_taken && !sync_load && pend_idx != 8'h00 && !ext_held)
        |=> $stable(pend_idx));

    p_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (!trap_taken && !sync_load && !any_lvl && ext_held)
        |=> pend_idx == 8'h00);

    p_irq_type_r2: assert property (@(posedge clk) disable iff (rst)
        (!trap_taken && !sync_load && any_lvl && (pend_idx == 8'h00 || ext_held))
        |=> pend_idx[7:4] == 4'h1 && pend_idx[3:0] != 4'h0);

    p_kick_change_r7: assert property (@(posedge clk) disable iff (rst)
        core_kick |-> (pend_idx != 8'h00) && (pend_idx != $past(pend_idx)));
endmodule

bind irl_resolver irl_resolver_chk u_chk (.*);

// File: tb/irl_resolver_tb.sv
module irl_resolver_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_lines = '0;
    logic        sync_load = 1'b0;
    logic [7:0]  sync_idx = '0;
    logic        trap_taken = 1'b0;
    logic [7:0]  pend_idx;
    logic        core_req;
    logic        core_kick;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string tag = "R1";

    logic [7:0] m_idx  = '0;
    logic       m_req  = 1'b0;
    logic       m_kick = 1'b0;

    always #5 clk = ~clk;

    irl_resolver u_dut (.*);

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        logic [7:0] nx;
        int top;
        top = 0;
        for (int i = 1; i < 16; i++) if (irq_lines[i]) top = i;
        nx = m_idx;
        if (rst) begin
            m_idx <= 8'h00; m_req <= 1'b0; m_kick <= 1'b0;
        end else begin
            if (trap_taken) nx = 8'h00;
            else if (sync_load) nx = sync_idx;
            else if (top != 0 && (m_idx == 8'h00 || m_idx[7:4] == 4'h1)) nx = 8'h10 + 8'(top);
            else if (top == 0 && m_idx[7:4] == 4'h1) nx = 8'h00;
            m_kick <= (nx != m_idx) && (nx != 8'h00);
            m_req  <= (nx != 8'h00);
            m_idx  <= nx;
        end
    end

    task automatic chk(input string t, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0h expected %0h", t, what, got, exp);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        cycles++;
        chk(tag, "pend_idx", pend_idx, m_idx);
        chk(tag, "core_req", core_req, m_req);
        chk(tag, "core_kick", core_kick, m_kick);
    end

    task automatic step(input logic [15:0] l, input logic ld, input logic [7:0] li,
                        input logic ack, input int n);
        @(negedge clk);
        irq_lines = l; sync_load = ld; sync_idx = li; trap_taken = ack;
        repeat (n - 1) @(negedge clk);
        @(negedge clk);
        irq_lines = irq_lines; sync_load = 1'b0; trap_taken = 1'b0;
    endtask

    always @(negedge clk) begin
        if (cycles > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        chk("R1", "reset idx", pend_idx, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "idx after release", pend_idx, 0);
        chk("R1", "kick after release", core_kick, 0);

        tag = "R3";
        step(16'h0001, 0, 8'h00, 0, 3);
        chk("R3", "bit0 only", pend_idx, 8'h00);

        tag = "R2";
        step(16'h0020, 0, 8'h00, 0, 1);
        chk("R2", "level 5", pend_idx, 8'h15);
        step(16'h8021, 0, 8'h00, 0, 1);
        chk("R2", "level 15 wins", pend_idx, 8'h1F);
        step(16'h00FE, 0, 8'h00, 0, 1);
        chk("R2", "level 7 wins", pend_idx, 8'h17);
        for (int k = 1; k < 16; k++) step(16'(1) << k, 0, 8'h00, 0, 1);
        chk("R2", "level 15 single", pend_idx, 8'h1F);

        tag = "R7";
        step(16'h8000, 0, 8'h00, 0, 4);
        chk("R7", "no kick when unchanged", core_kick, 0);
        step(16'h0400, 0, 8'h00, 0, 1);
        chk("R7", "kick on change", core_kick, 1);

        tag = "R5";
        step(16'h0001, 0, 8'h00, 0, 2);
        chk("R5", "drop idx", pend_idx, 8'h00);
        chk("R5", "drop req", core_req, 0);
        chk("R7", "no kick on drop", core_kick, 0);

        tag = "R8";
        step(16'h4000, 1, 8'h2B, 0, 1);
        chk("R8", "load wins", pend_idx, 8'h2B);
        chk("R10", "req with load", core_req, 1);

        tag = "R4";
        step(16'h8000, 0, 8'h00, 0, 2);
        step(16'h0006, 0, 8'h00, 0, 2);
        chk("R4", "sync kept", pend_idx, 8'h2B);

        tag = "R6";
        step(16'h0000, 0, 8'h00, 0, 3);
        chk("R6", "sync kept idle", pend_idx, 8'h2B);

        tag = "R9";
        step(16'h0100, 1, 8'h33, 1, 1);
        chk("R9", "accept wins", pend_idx, 8'h00);
        chk("R10", "req low after accept", core_req, 0);
        step(16'h0100, 0, 8'h00, 0, 2);
        chk("R2", "resume after accept", pend_idx, 8'h18);

        tag = "R8";
        step(16'h0000, 1, 8'h13, 0, 1);
        step(16'h0200, 0, 8'h00, 0, 1);
        chk("R2", "loaded ext replaced", pend_idx, 8'h19);
        step(16'h0200, 1, 8'h00, 0, 1);
        chk("R10", "load zero req", core_req, 0);
        step(16'h0000, 0, 8'h00, 0, 2);
        step(16'h0000, 1, 8'h07, 0, 1);
        step(16'h0000, 1, 8'h07, 0, 1);
        chk("R7", "reload same no kick", core_kick, 0);
        step(16'h0000, 0, 8'h00, 1, 2);

        tag = "R1";
        @(negedge clk);
        rst = 1'b1;
        irq_lines = 16'hFFFE;
        @(negedge clk);
        chk("R1", "reset overrides", pend_idx, 8'h00);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule